// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

The block multiplies two unsigned operands of `WIDTH` bits (32 by default) over several clock cycles and returns a `2*WIDTH`-bit product. It uses a single adder of `WIDTH` bits and one product register of `2*WIDTH` bits. There is no separate register for the multiplier: the multiplier is placed in the lower half of the product register and is used up one bit at a time as that register shifts right. Only the multiplicand has a register of its own.

A one-cycle `start_i` pulse in an idle or finished state loads both operands. The block then runs one iteration per clock for `WIDTH` clocks. Each iteration looks at product bit 0. If that bit is 1, the multiplicand is added to the upper half. The register then shifts right by one, with the adder's carry entering the top bit. When the last iteration ends, `done_o` goes high. The upper and lower product halves are always visible on `hi_o` and `lo_o`, so the state in the middle of a run can be seen at the ports.

Top module: `shift_add_mul`

## Requirements
- R1: When `done_o` is high, `{hi_o, lo_o}` equals the unsigned product `mcand_i * mplier_i` of the operands loaded by the last accepted start, over the full `2*WIDTH` bits.
- R2: A start is accepted when `start_i` is high while `busy_o` is low. On the clock edge that accepts it, `hi_o` is cleared to zero, `lo_o` takes `mplier_i`, the multiplicand is captured, `busy_o` rises and `done_o` falls.
- R3: In an iteration where product bit 0 (`lo_o[0]`) is 1, the multiplicand is added to the upper half. The `WIDTH+1`-bit sum and the lower half then shift right by one together, so the carry lands in bit `2*WIDTH-1`.
- R4: In an iteration where product bit 0 is 0, the whole product register only shifts right by one, with a zero entering the top bit.
- R5: `done_o` rises exactly `WIDTH` clock edges after the edge that accepted the start. `busy_o` is high for exactly those `WIDTH` cycles.
- R6: After completion, `done_o` stays high and `{hi_o, lo_o}` holds its value until the next accepted start. `busy_o` and `done_o` are never high together.
- R7: `start_i` is ignored while `busy_o` is high. A run keeps its original operands and its timing.
- R8: After reset, `busy_o` and `done_o` are low and `hi_o` and `lo_o` are zero.
- R9: Extreme operands give exact results. All-ones times all-ones gives `2^(2W) - 2^(W+1) + 1`, which needs the captured carry. A zero operand on either side gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; loads operands when not busy |
| mcand_i | input | WIDTH | Multiplicand |
| mplier_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | Product complete and held |
| hi_o | output | WIDTH | Upper half of product register |
| lo_o | output | WIDTH | Lower half of product register |

## Verification
The assertions take for granted that the operand inputs are stable in the cycle that `start_i` is accepted. They make no assumption about `start_i` during a run, because the block must ignore it. The bench changes inputs only on the falling clock edge, and it holds each operand pair for the whole accepting cycle. It also sends extra starts with different operands in the middle of a run. These cases exercise the assumption without breaking it.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_e;
endpackage

// File: rtl/mul_adder.sv
module mul_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             en_i,
  output logic [WIDTH:0]   sum_o
);
  logic [WIDTH-1:0] b_gated;
  logic [WIDTH:0]   carry;

  assign b_gated  = en_i ? b_i : '0;
  assign carry[0] = 1'b0;

  // ripple chain; carry[WIDTH] is the carry-out kept for bit 2W-1
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum_o[i]   = a_i[i] ^ b_gated[i] ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_gated[i]) | (carry[i] & (a_i[i] ^ b_gated[i]));
  end
  assign sum_o[WIDTH] = carry[WIDTH];
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  mul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign load_o = start_i && !busy_o;
  assign step_o = busy_o;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (cnt_q == LAST) state_d = ST_DONE;
        else               cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_NO_BUSY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o)); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && cnt_q != LAST) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R6
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [PW-1:0]    prod_q, prod_d;
  logic [WIDTH:0]   sum;

  mul_adder #(.WIDTH(WIDTH)) u_add (
    .a_i  (prod_q[PW-1:WIDTH]),
    .b_i  (mcand_q),
    .en_i (prod_q[0]),
    .sum_o(sum)
  );

  always_comb begin
    prod_d = prod_q;
    if (load_i)      prod_d = {{WIDTH{1'b0}}, mplier_i};
    else if (step_i) prod_d = {sum, prod_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= '0;
      mcand_q <= '0;
    end else begin
      prod_q <= prod_d;
      if (load_i) mcand_q <= mcand_i;
    end
  end

  assign hi_o = prod_q[PW-1:WIDTH];
  assign lo_o = prod_q[WIDTH-1:0];

  AST_LOAD_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (hi_o == '0 && lo_o == $past(mplier_i))); // R2
  AST_SKIP_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !lo_o[0]) |=> ({hi_o, lo_o} == ($past({hi_o, lo_o}) >> 1))); // R4
  AST_ADD_LOW_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (lo_o[WIDTH-2:0] == $past(lo_o[WIDTH-1:1]))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable({hi_o, lo_o})); // R6
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  localparam int RW = $clog2(WIDTH + 1) + 1;

  logic load, step;

  mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
  );

  // independent run-length counter for the latency check
  logic [RW-1:0] run_cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cyc_q <= '0;
    else if (load)   run_cyc_q <= '0;
    else if (busy_o) run_cyc_q <= run_cyc_q + 1'b1;
  end

  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (run_cyc_q == RW'(WIDTH))); // R5
  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o)); // R2
endmodule

// File: tb/shift_add_mul_test.sv
module shift_add_mul_test;
  localparam int W  = 32;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          start, busy, done;
  logic [W-1:0]  a, b, hi, lo;
  logic          s_start, s_busy, s_done;
  logic [SW-1:0] s_a, s_b, s_hi, s_lo;

  shift_add_mul #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mcand_i(a), .mplier_i(b),
    .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo)
  );

  shift_add_mul #(.WIDTH(SW)) uut_small (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s_start), .mcand_i(s_a), .mplier_i(s_b),
    .busy_o(s_busy), .done_o(s_done), .hi_o(s_hi), .lo_o(s_lo)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // exhaustive small-width run: load, first iteration, latency, result
  task automatic run_small(input logic [SW-1:0] x, input logic [SW-1:0] y);
    logic [2*SW-1:0] exp_p, exp1;
    exp_p = (2*SW)'(x) * (2*SW)'(y);
    exp1  = ((y[0] ? ((2*SW)'(x) << SW) : '0) + (2*SW)'(y)) >> 1;
    @(negedge clk);
    s_a = x; s_b = y; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0; s_a = ~x; s_b = ~y;
    chk(s_hi == '0 && s_lo == y && s_busy && !s_done, "R2 load", {s_hi, s_lo}, 64'(y));
    for (int k = 1; k <= SW; k++) begin
      @(negedge clk);
      if (k == 1)
        chk({s_hi, s_lo} == exp1, y[0] ? "R3 add-shift" : "R4 shift-only", {s_hi, s_lo}, exp1);
      if (k < SW)
        chk(s_busy && !s_done, "R5 still busy", {s_busy, s_done}, 64'd2);
    end
    chk(s_done && !s_busy, "R5 done timing", {s_busy, s_done}, 64'd1);
    chk({s_hi, s_lo} == exp_p, "R1 small product", {s_hi, s_lo}, exp_p);
  endtask

  task automatic run_wide(input logic [W-1:0] x, input logic [W-1:0] y, input bit poke, input string req);
    logic [63:0] exp_p;
    exp_p = 64'(x) * 64'(y);
    @(negedge clk);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(hi == '0 && lo == y && busy && !done, "R2 wide load", {hi, lo}, 64'(y));
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && (k == 3 || k == W - 1)) begin
        a = 32'hDEAD_BEEF; b = 32'h1234_5678; start = 1'b1;
      end
      if (k == W - 1) chk(busy && !done, "R7 no early done", {busy, done}, 64'd2);
    end
    start = 1'b0;
    chk(done && !busy, "R5 wide done timing", {busy, done}, 64'd1);
    chk({hi, lo} == exp_p, req, {hi, lo}, exp_p);
    repeat (3) @(negedge clk);
    chk(done && !busy && {hi, lo} == exp_p, "R6 result held", {hi, lo}, exp_p);
  endtask

  initial begin
    start = 1'b0; a = '0; b = '0;
    s_start = 1'b0; s_a = '0; s_b = '0;
    repeat (2) @(negedge clk);
    chk(!busy && !done && hi == '0 && lo == '0, "R8 reset", {hi, lo}, 64'd0);
    chk(!s_busy && !s_done && s_hi == '0 && s_lo == '0, "R8 reset small", {s_hi, s_lo}, 64'd0);
    rst_n = 1'b1;

    for (int x = 0; x < (1 << SW); x++)
      for (int y = 0; y < (1 << SW); y++)
        run_small(SW'(x), SW'(y));

    run_wide('1, '1, 1'b0, "R9 all-ones");
    run_wide('0, 32'hFFFF_FFFF, 1'b0, "R9 zero multiplicand");
    run_wide(32'h8765_4321, '0, 1'b0, "R9 zero multiplier");
    run_wide(32'h0000_0002, 32'h0000_0007, 1'b0, "R1 small values");
    run_wide(32'h8000_0000, 32'h8000_0001, 1'b0, "R3 carry into top");
    run_wide(32'hCAFE_F00D, 32'h0BAD_C0DE, 1'b1, "R7 start ignored");
    begin
      logic [31:0] lx = 32'h1357_9BDF;
      logic [31:0] ly = 32'h2468_ACE0;
      for (int i = 0; i < 20; i++) begin
        lx = lx * 32'd1664525 + 32'd1013904223;
        ly = ly ^ (ly << 13); ly = ly ^ (ly >> 17); ly = ly ^ (ly << 5);
        run_wide(lx, ly, i[0], "R1 pseudo-random");
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule